// File: doc/BRIEF.md
# Message Buffer Interrupt Controller

This block gathers completion events for the 64 message buffers of a CAN-style controller and turns them into one interrupt request. Each buffer owns a pending flag and an enable bit. The transmit and receive engines send a one-cycle completion pulse for a buffer, and that pulse sets the buffer's flag. The CPU sees the flags and enables through four 32-bit registers. It clears flags by writing ones. The interrupt line is high while any buffer has both its flag and its enable set.

The block also protects buffers that are still waiting for the CPU. When the abort control input is high, every transmit buffer whose flag is pending raises its write-block output. The message-buffer RAM uses this output to refuse CPU writes to that buffer's contents. The output is combinational, so it gates a write in the same cycle that the write is requested.

Top module: `mbuf_irq_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset, all enable bits and all flag bits are 0, and `irq_o` and `reg_rdata` are 0.
- R2: The enable registers can be read and written. Buffers 0–31 sit at offset 0x28 and buffers 32–63 at offset 0x24. Bit k of a word belongs to buffer k of that half, so buffer 31 is bit 31 of 0x28. An enable value of 1 enables the buffer.
- R3: A pulse on `evt_done[n]` sets flag n. Flags for buffers 0–31 read at offset 0x30 and flags for buffers 32–63 at offset 0x2C. Bit positions follow the same rule as R2.
- R4: Writing 1 to a flag bit clears it. Writing 0 to a flag bit leaves it unchanged.
- R5: If a completion pulse and a write-1-to-clear reach the same flag in the same cycle, the flag ends up set.
- R6: `irq_o` is the registered OR, over all buffers, of flag AND enable. It follows a flag change one clock later.
- R7: Setting an enable bit while its flag is set raises `irq_o` one clock after the register write. Clearing that enable bit drops `irq_o` one clock after the write, provided no other enabled flag is pending.
- R8: `wr_block[n]` equals `abort_en` AND `buf_is_tx[n]` AND flag n, with no clock delay.
- R9: A read presents its data on `reg_rdata` one clock after `reg_rd`. A read does not change any state. An address other than the four register offsets reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| evt_done | input | 64 | Per-buffer completion pulse |
| buf_is_tx | input | 64 | Per-buffer direction, 1 = transmit |
| abort_en | input | 1 | Abort mode enable |
| irq_o | output | 1 | Interrupt request, registered |
| wr_block | output | 64 | Per-buffer CPU write block |

## Verification
Two things can hit the same flag in the same cycle: a completion pulse from an engine and a CPU write-1-to-clear. The bench provokes this by pulsing one buffer's completion on the exact edge where the CPU writes a clear word that covers that buffer and a second buffer that is already set. It then reads the flag word back and expects the colliding buffer still set and the other buffer cleared. The rest of the bench sweeps all 64 buffers through four stages in turn: set, enable, mask toggling and clear. For each buffer it also tries every combination of abort and direction.

// File: rtl/mbuf_irq_pkg.sv
package mbuf_irq_pkg;
  // Word 0 holds buffers 0..WORD_W-1; higher words step downward by 4 bytes.
  localparam int ENA_BASE  = 'h28;
  localparam int PEND_BASE = 'h30;

  function automatic int ena_ofs(input int w);
    return ENA_BASE - 4 * w;
  endfunction

  function automatic int pend_ofs(input int w);
    return PEND_BASE - 4 * w;
  endfunction
endpackage

// File: rtl/mbuf_irq_ena_word.sv
module mbuf_irq_ena_word #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] ena_q
);
  always_ff @(posedge clk) begin
    if (rst)        ena_q <= '0;
    else if (wr_en) ena_q <= wdata;
  end
endmodule

// File: rtl/mbuf_irq_pend_word.sv
module mbuf_irq_pend_word #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic [WORD_W-1:0] clr_bits,
  input  logic [WORD_W-1:0] set_bits,
  output logic [WORD_W-1:0] pend_q
);
  logic [WORD_W-1:0] clr_eff;

  always_comb clr_eff = clr_en ? clr_bits : '0;

  // Hardware set is ORed in after the clear, so a colliding event survives.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_eff) | set_bits;
  end
endmodule

// File: rtl/mbuf_irq_reduce.sv
module mbuf_irq_reduce #(
  parameter int NBUF = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NBUF-1:0] pend,
  input  logic [NBUF-1:0] ena,
  output logic            irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend & ena);
  end
endmodule

// File: rtl/mbuf_irq_ctrl.sv
module mbuf_irq_ctrl #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [WORD_W-1:0]           reg_wdata,
  output logic [WORD_W-1:0]           reg_rdata,
  input  logic [WORD_W*NUM_WORDS-1:0] evt_done,
  input  logic [WORD_W*NUM_WORDS-1:0] buf_is_tx,
  input  logic                        abort_en,
  output logic                        irq_o,
  output logic [WORD_W*NUM_WORDS-1:0] wr_block
);
  import mbuf_irq_pkg::*;

  localparam int NBUF = WORD_W * NUM_WORDS;

  logic [NBUF-1:0]   pend_vec;
  logic [NBUF-1:0]   ena_vec;
  logic [WORD_W-1:0] rd_next;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic ena_hit;
    logic pend_hit;

    always_comb begin
      ena_hit  = reg_wr && (reg_addr == ADDR_W'(ena_ofs(w)));
      pend_hit = reg_wr && (reg_addr == ADDR_W'(pend_ofs(w)));
    end

    mbuf_irq_ena_word #(.WORD_W(WORD_W)) u_ena (
      .clk   (clk),
      .rst   (rst),
      .wr_en (ena_hit),
      .wdata (reg_wdata),
      .ena_q (ena_vec[w*WORD_W +: WORD_W])
    );

    mbuf_irq_pend_word #(.WORD_W(WORD_W)) u_pend (
      .clk      (clk),
      .rst      (rst),
      .clr_en   (pend_hit),
      .clr_bits (reg_wdata),
      .set_bits (evt_done[w*WORD_W +: WORD_W]),
      .pend_q   (pend_vec[w*WORD_W +: WORD_W])
    );
  end

  mbuf_irq_reduce #(.NBUF(NBUF)) u_reduce (
    .clk   (clk),
    .rst   (rst),
    .pend  (pend_vec),
    .ena   (ena_vec),
    .irq_q (irq_o)
  );

  always_comb begin
    rd_next = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (reg_addr == ADDR_W'(ena_ofs(w)))  rd_next = ena_vec[w*WORD_W +: WORD_W];
      if (reg_addr == ADDR_W'(pend_ofs(w))) rd_next = pend_vec[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end

  // Combinational so the buffer RAM can refuse a write in the same cycle.
  always_comb wr_block = {NBUF{abort_en}} & buf_is_tx & pend_vec;
endmodule

// File: rtl/mbuf_irq_chk.sv
module mbuf_irq_chk #(
  parameter int NBUF   = 64,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [WORD_W-1:0] reg_rdata,
  input logic [NBUF-1:0]   evt_done,
  input logic [NBUF-1:0]   buf_is_tx,
  input logic              abort_en,
  input logic              irq_o,
  input logic [NBUF-1:0]   wr_block,
  input logic [NBUF-1:0]   pend_vec,
  input logic [NBUF-1:0]   ena_vec
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq_o && reg_rdata == '0));

  assert_irq_needs_pend_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_vec == '0) |=> !irq_o);

  assert_irq_needs_ena_R7: assert property (@(posedge clk) disable iff (rst)
    (ena_vec == '0) |=> !irq_o);

  assert_block_needs_abort_R8: assert property (@(posedge clk) disable iff (rst)
    !abort_en |-> (wr_block == '0));

  assert_block_tx_only_R8: assert property (@(posedge clk) disable iff (rst)
    ((wr_block & ~buf_is_tx) == '0));

  for (genvar g = 0; g < NBUF; g++) begin : g_bit
    assert_event_sets_R5: assert property (@(posedge clk) disable iff (rst)
      evt_done[g] |=> pend_vec[g]);

    assert_clear_by_write_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(pend_vec[g]) |-> $past(reg_wr));
  end
endmodule

bind mbuf_irq_ctrl mbuf_irq_chk #(.NBUF(WORD_W*NUM_WORDS), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .evt_done  (evt_done),
  .buf_is_tx (buf_is_tx),
  .abort_en  (abort_en),
  .irq_o     (irq_o),
  .wr_block  (wr_block),
  .pend_vec  (pend_vec),
  .ena_vec   (ena_vec)
);

// File: tb/mbuf_irq_ctrl_test.sv
`timescale 1ns/100ps
module mbuf_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] evt_done = '0;
  logic [63:0] buf_is_tx = '0;
  logic        abort_en = 1'b0;
  logic        irq_o;
  logic [63:0] wr_block;

  logic [63:0] m_pend = '0;
  logic [63:0] m_ena = '0;
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  mbuf_irq_ctrl uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_done(evt_done), .buf_is_tx(buf_is_tx), .abort_en(abort_en),
    .irq_o(irq_o), .wr_block(wr_block)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 200000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [7:0] a_ena(input int w);
    return (w == 0) ? 8'h28 : 8'h24;
  endfunction

  function automatic logic [7:0] a_pend(input int w);
    return (w == 0) ? 8'h30 : 8'h2C;
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    tick;
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input int n);
    evt_done = 64'd1 << n;
    tick;
    evt_done = '0;
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] d2;
    tick; tick;
    rst = 1'b0;
    // R1: reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 wr_block", wr_block, 0);
    for (int w = 0; w < 2; w++) begin
      rd(a_ena(w), d);  chk("R1 ena", d, 0);
      rd(a_pend(w), d); chk("R1 pend", d, 0);
    end

    // R2: enable register read/write
    wr(8'h28, 32'hA5A5_0001); rd(8'h28, d); chk("R2 low ena", d, 32'hA5A5_0001);
    wr(8'h24, 32'h8000_00FF); rd(8'h24, d); chk("R2 high ena", d, 32'h8000_00FF);
    rd(8'h28, d); chk("R2 low ena kept", d, 32'hA5A5_0001);
    chk("R6 no pend no irq", irq_o, 0);
    wr(8'h28, 0); wr(8'h24, 0);

    // R9: unmapped read returns 0
    rd(8'h2C + 8'h10, d); chk("R9 unmapped", d, 0);

    // Sweep every buffer
    for (int i = 0; i < 64; i++) begin
      int w;
      int b;
      w = i / 32;
      b = i % 32;
      pulse(i); m_pend[i] = 1'b1;
      tick;
      chk("R6 masked pend", irq_o, |(m_pend & m_ena));
      rd(a_pend(w), d);  chk("R3 pend set", d, m_pend[w*32 +: 32]);
      rd(a_pend(w), d2); chk("R9 reread", d2, d);
      for (int a = 0; a < 4; a++) begin
        abort_en  = a[0];
        buf_is_tx = a[1] ? (64'd1 << i) : 64'd0;
        #1;
        chk("R8 wr_block", wr_block, (a == 3) ? (64'd1 << i) : 64'd0);
      end
      abort_en = 1'b0; buf_is_tx = '0;
      m_ena[i] = 1'b1; wr(a_ena(w), m_ena[w*32 +: 32]); tick;
      chk("R7 enable raises irq", irq_o, 1);
      wr(a_pend(w), 32'h0); tick;
      rd(a_pend(w), d); chk("R4 write zero keeps", d, m_pend[w*32 +: 32]);
      chk("R4 irq kept", irq_o, 1);
      m_ena[i] = 1'b0; wr(a_ena(w), m_ena[w*32 +: 32]); tick;
      chk("R7 disable drops irq", irq_o, 0);
      m_ena[i] = 1'b1; wr(a_ena(w), m_ena[w*32 +: 32]); tick;
      wr(a_pend(w), 32'd1 << b); m_pend[i] = 1'b0; tick;
      chk("R6 clear drops irq", irq_o, 0);
      rd(a_pend(w), d); chk("R4 write one clears", d, m_pend[w*32 +: 32]);
      m_ena[i] = 1'b0; wr(a_ena(w), m_ena[w*32 +: 32]);
    end

    // R5: set and clear collide on buffer 5; buffer 6 just clears
    pulse(6);
    reg_wr = 1'b1; reg_addr = 8'h30; reg_wdata = 32'h0000_0060;
    evt_done = 64'd1 << 5;
    tick;
    reg_wr = 1'b0; evt_done = '0;
    rd(8'h30, d); chk("R5 set wins", d, 32'h0000_0020);
    wr(8'h30, 32'h0000_0020);

    // R6: several pending, only one enabled
    pulse(3); pulse(40);
    wr(8'h24, 32'd1 << 8); tick;
    chk("R6 one enabled", irq_o, 1);
    wr(8'h2C, 32'd1 << 8); tick;
    chk("R6 other pend masked", irq_o, 0);
    rd(8'h30, d); chk("R3 low pend left", d, 32'h0000_0008);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule